// File: doc/BRIEF.md
# Processor Presence Bitmap

This block keeps one presence bit for every processor identifier and lets software read the whole set as a window of 32 read-only byte registers. Identifier `n` lives in byte `n/8`, bit `n%8`, so byte `k` of the window describes identifiers `8k` to `8k+7`. The set that is present at power-on comes from a parameter and is loaded while reset is held.

Two sideband request streams change the set: a plug stream sets the bit of its identifier and an unplug stream clears it. Each stream is valid/ready; ready is always high, so the block never applies back-pressure and every request seen with valid high is taken in that cycle. Each accepted request, whether or not it changes the bit, pulses an event strobe that the general-purpose event logic uses to set its status bit 2 (mask 0x04) and re-evaluate its interrupt. Identifiers at or above the configured processor count are dropped and pulse an error flag instead.

The register window answers only single-byte reads; wider accesses return zero. Bus writes are taken and have no effect on the set.

Top module: `cpuhp_presence`

## Requirements
- R1: While reset is held, each presence bit `i` is loaded from bit `i` of the initial-set parameter for `i` below the processor count; every bit at or above the count reads as zero.
- R2: A byte read (`bus_size` = 0) of offset `k` returns byte `k` of the bitmap on `bus_rdata` in the cycle after the read is issued, identifier `n` being bit `n%8` of byte `n/8`.
- R3: An accepted plug request with an in-range identifier sets that identifier's bit from the next cycle on.
- R4: An accepted unplug request with an in-range identifier clears that identifier's bit from the next cycle on.
- R5: When plug and unplug name the same identifier in one cycle, the bit ends cleared; requests on different identifiers in one cycle are both applied.
- R6: Every in-range plug or unplug request causes `gpe_cpu_set` to be high for the following cycle, even when the bit did not change; with no such request it is low.
- R7: A request whose identifier is not below the processor count leaves the bitmap unchanged, does not raise `gpe_cpu_set`, and raises `id_error` for the following cycle.
- R8: A read whose `bus_size` is not 0 (1 = two bytes, 2 = four bytes, 3 = reserved) returns zero and changes nothing.
- R9: Bus writes never change the bitmap.
- R10: `plug_ready` and `unplug_ready` are always high out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plug_valid | input | 1 | Plug request present |
| plug_ready | output | 1 | Plug request taken (always high) |
| plug_id | input | 8 | Identifier to mark present |
| unplug_valid | input | 1 | Unplug request present |
| unplug_ready | output | 1 | Unplug request taken (always high) |
| unplug_id | input | 8 | Identifier to mark absent |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe (discarded) |
| bus_addr | input | 5 | Byte offset in the window |
| bus_size | input | 2 | Access width: 0 byte, 1 half, 2 word, 3 reserved |
| bus_rdata | output | 8 | Read data, registered |
| gpe_cpu_set | output | 1 | One-cycle strobe to set event status bit 2 |
| id_error | output | 1 | One-cycle strobe for an out-of-range identifier |

## Verification
On every cycle the assertions check that an in-range request is followed by the event strobe, an out-of-range one by the error flag and an unchanged bitmap, a same-identifier conflict by a cleared bit, a wide read by zero data, and a write with no request by a stable bitmap. Only the bench scenarios show the actual byte packing of identifiers, the reset contents taken from the parameter with the out-of-range initial bits dropped, and the combined effect of two different identifiers in one cycle as seen through register reads.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;
  localparam int ID_W      = 8;
  localparam int MAP_BITS  = 1 << ID_W;
  localparam int WIN_BYTES = MAP_BITS / 8;
  localparam int OFS_W     = $clog2(WIN_BYTES);

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/cpuhp_req_decode.sv
module cpuhp_req_decode
  import cpuhp_pkg::*;
#(
  parameter int NUM_CPUS = MAP_BITS
) (
  input  logic                valid,
  input  logic [ID_W-1:0]     id,
  output logic [MAP_BITS-1:0] mask,
  output logic                hit,
  output logic                miss
);
  logic in_range;
  assign in_range = ({1'b0, id} < (ID_W+1)'(NUM_CPUS));
  assign hit      = valid && in_range;
  assign miss     = valid && !in_range;

  for (genvar i = 0; i < MAP_BITS; i++) begin : g_bit
    assign mask[i] = hit && (id == ID_W'(i));
  end
endmodule

// File: rtl/cpuhp_bitmap.sv
module cpuhp_bitmap
  import cpuhp_pkg::*;
#(
  parameter int                NUM_CPUS  = MAP_BITS,
  parameter logic [MAP_BITS-1:0] INIT_MASK = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAP_BITS-1:0] set_mask,
  input  logic [MAP_BITS-1:0] clr_mask,
  output logic [MAP_BITS-1:0] bits
);
  for (genvar i = 0; i < MAP_BITS; i++) begin : g_cell
    if (i < NUM_CPUS) begin : g_live
      logic cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cell_q <= INIT_MASK[i];
        else if (clr_mask[i]) cell_q <= 1'b0;
        else if (set_mask[i]) cell_q <= 1'b1;
      end
      assign bits[i] = cell_q;

      AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_mask[i] |=> !bits[i]); // R5
    end else begin : g_dead
      assign bits[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cpuhp_read_port.sv
module cpuhp_read_port
  import cpuhp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAP_BITS-1:0] bits,
  input  logic                rd,
  input  logic [OFS_W-1:0]    addr,
  input  logic [1:0]          size,
  output logic [7:0]          rdata
);
  logic [7:0] bytes [WIN_BYTES];
  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
    assign bytes[b] = bits[b*8 +: 8];
  end

  logic [7:0] rdata_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (rd && acc_size_e'(size) == ACC_BYTE)
      rdata_q <= bytes[addr];
    else
      rdata_q <= '0;
  end
  assign rdata = rdata_q;

  AST_WIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && size != 2'd0) |=> (rdata == 8'd0)); // R8
endmodule

// File: rtl/cpuhp_presence.sv
module cpuhp_presence
  import cpuhp_pkg::*;
#(
  parameter int                  NUM_CPUS  = MAP_BITS,
  parameter logic [MAP_BITS-1:0] INIT_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             plug_valid,
  output logic             plug_ready,
  input  logic [ID_W-1:0]  plug_id,
  input  logic             unplug_valid,
  output logic             unplug_ready,
  input  logic [ID_W-1:0]  unplug_id,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [1:0]       bus_size,
  output logic [7:0]       bus_rdata,
  output logic             gpe_cpu_set,
  output logic             id_error
);
  logic [MAP_BITS-1:0] set_mask, clr_mask, bitmap;
  logic plug_hit, plug_miss, unplug_hit, unplug_miss;

  cpuhp_req_decode #(.NUM_CPUS(NUM_CPUS)) u_plug_dec (
    .valid(plug_valid), .id(plug_id),
    .mask(set_mask), .hit(plug_hit), .miss(plug_miss)
  );

  cpuhp_req_decode #(.NUM_CPUS(NUM_CPUS)) u_unplug_dec (
    .valid(unplug_valid), .id(unplug_id),
    .mask(clr_mask), .hit(unplug_hit), .miss(unplug_miss)
  );

  cpuhp_bitmap #(.NUM_CPUS(NUM_CPUS), .INIT_MASK(INIT_MASK)) u_map (
    .clk(clk), .rst_n(rst_n),
    .set_mask(set_mask), .clr_mask(clr_mask), .bits(bitmap)
  );

  cpuhp_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .bits(bitmap),
    .rd(bus_rd), .addr(bus_addr), .size(bus_size), .rdata(bus_rdata)
  );

  logic gpe_q, err_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpe_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      gpe_q <= plug_hit || unplug_hit;
      err_q <= plug_miss || unplug_miss;
    end
  end

  assign gpe_cpu_set  = gpe_q;
  assign id_error     = err_q;
  assign plug_ready   = rst_n;
  assign unplug_ready = rst_n;

  AST_EVENT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ((plug_valid && {1'b0, plug_id} < (ID_W+1)'(NUM_CPUS)) ||
     (unplug_valid && {1'b0, unplug_id} < (ID_W+1)'(NUM_CPUS))) |=> gpe_cpu_set); // R6

  AST_BAD_ID_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((plug_valid && {1'b0, plug_id} >= (ID_W+1)'(NUM_CPUS)) && !unplug_valid)
      |=> (id_error && $stable(bitmap) && !gpe_cpu_set)); // R7

  AST_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !plug_valid && !unplug_valid) |=> $stable(bitmap)); // R9

  AST_SAME_ID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (plug_valid && unplug_valid && plug_id == unplug_id &&
     {1'b0, unplug_id} < (ID_W+1)'(NUM_CPUS)) |=> !bitmap[$past(unplug_id)]); // R5

  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    plug_ready && unplug_ready); // R10
endmodule

// File: tb/cpuhp_presence_tb.sv
module cpuhp_presence_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 200;
  localparam logic [255:0] INIT = (256'd1 << 0) | (256'd1 << 1) | (256'd1 << 2) |
                                  (256'd1 << 9) | (256'd1 << 250);

  logic clk = 0, rst_n = 0;
  logic plug_valid = 0, unplug_valid = 0, bus_rd = 0, bus_wr = 0;
  logic [7:0] plug_id = 0, unplug_id = 0;
  logic [4:0] bus_addr = 0;
  logic [1:0] bus_size = 0;
  logic plug_ready, unplug_ready, gpe_cpu_set, id_error;
  logic [7:0] bus_rdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuhp_presence #(.NUM_CPUS(NCPU), .INIT_MASK(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .plug_valid(plug_valid), .plug_ready(plug_ready), .plug_id(plug_id),
    .unplug_valid(unplug_valid), .unplug_ready(unplug_ready), .unplug_id(unplug_id),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_rdata(bus_rdata), .gpe_cpu_set(gpe_cpu_set), .id_error(id_error)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd_byte(input logic [4:0] a, input logic [1:0] sz, output logic [7:0] d);
    bus_rd = 1; bus_addr = a; bus_size = sz;
    @(posedge clk); @(negedge clk);
    bus_rd = 0; bus_size = 0;
    d = bus_rdata;
  endtask

  task automatic request(input logic p, input logic [7:0] pid, input logic u, input logic [7:0] uid,
                         input string req, input logic exp_gpe, input logic exp_err);
    plug_valid = p; plug_id = pid; unplug_valid = u; unplug_id = uid;
    @(posedge clk); @(negedge clk);
    plug_valid = 0; unplug_valid = 0;
    check({req, " gpe strobe"}, {7'd0, gpe_cpu_set}, {7'd0, exp_gpe});
    check({req, " id error"}, {7'd0, id_error}, {7'd0, exp_err});
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 gpe idle", {7'd0, gpe_cpu_set}, 8'd0);
    check("R10 ready", {6'd0, plug_ready, unplug_ready}, 8'h03);
    rd_byte(5'd0, 2'd0, d); check("R1 R2 byte0", d, 8'h07);
    rd_byte(5'd1, 2'd0, d); check("R1 R2 byte1", d, 8'h02);
    rd_byte(5'd31, 2'd0, d); check("R1 byte31 beyond count", d, 8'h00);
  endtask

  task automatic t_plug_unplug;
    logic [7:0] d;
    request(1, 8'd17, 0, 8'd0, "R6 plug", 1, 0);
    rd_byte(5'd2, 2'd0, d); check("R3 plug id17", d, 8'h02);
    request(0, 8'd0, 1, 8'd1, "R6 unplug", 1, 0);
    rd_byte(5'd0, 2'd0, d); check("R4 unplug id1", d, 8'h05);
    request(1, 8'd17, 0, 8'd0, "R6 replug no change", 1, 0);
    rd_byte(5'd2, 2'd0, d); check("R3 id17 still set", d, 8'h02);
  endtask

  task automatic t_conflict;
    logic [7:0] d;
    request(1, 8'd40, 1, 8'd40, "R5 same id", 1, 0);
    rd_byte(5'd5, 2'd0, d); check("R5 same id cleared", d, 8'h00);
    request(1, 8'd41, 1, 8'd0, "R5 two ids", 1, 0);
    rd_byte(5'd5, 2'd0, d); check("R5 plug id41", d, 8'h02);
    rd_byte(5'd0, 2'd0, d); check("R5 unplug id0", d, 8'h04);
  endtask

  task automatic t_range;
    logic [7:0] d;
    request(1, 8'd199, 0, 8'd0, "R6 top id", 1, 0);
    rd_byte(5'd24, 2'd0, d); check("R3 id199", d, 8'h80);
    request(1, 8'd210, 0, 8'd0, "R7 plug out of range", 0, 1);
    rd_byte(5'd26, 2'd0, d); check("R7 byte26 unchanged", d, 8'h00);
    request(0, 8'd0, 1, 8'd255, "R7 unplug out of range", 0, 1);
  endtask

  task automatic t_bus;
    logic [7:0] d;
    rd_byte(5'd0, 2'd2, d); check("R8 word read zero", d, 8'h00);
    rd_byte(5'd1, 2'd1, d); check("R8 half read zero", d, 8'h00);
    bus_wr = 1; bus_addr = 5'd0;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
    rd_byte(5'd0, 2'd0, d); check("R9 write ignored byte0", d, 8'h04);
    rd_byte(5'd1, 2'd0, d); check("R2 byte1 after all", d, 8'h02);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_plug_unplug();
        t_conflict();
        t_range();
        t_bus();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule